// File: doc/BRIEF.md
# GPIO Port with Pin Interrupts

This block is one general-purpose I/O port of up to 32 pins, controlled through a plain 32-bit register bus. Each pin has a function code that decides whether the pad driver is on. It also has an output data bit, a 2-bit pull setting and a 2-bit drive-strength setting, all taken straight from registers to the pad ring. Pin input levels pass through a two-flop synchroniser. Software reads them back from the same data address that it writes the outputs to.

Each pin can also raise an interrupt. The synchronised levels are looked at only on sample events. A sample event is one pulse from a chosen tick source (a slow tick or a fast tick, both single-cycle enables in the bus clock domain), divided by a power-of-two prescaler. A per-pin trigger code picks a rising edge, a falling edge, either edge, a high level or a low level. A match sets a pending bit, and software clears pending bits by writing ones to them. One interrupt line goes out: it is high while any pending pin is also enabled.

The register bus has no back-pressure. Every access with `bus_sel` high completes in its own cycle. A write takes effect at that clock edge. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low. Register byte offsets are:

| Offset | Register |
|--------|----------|
| 0x00 to 0x0C | function codes |
| 0x10 | pin data |
| 0x14 and 0x18 | pull fields |
| 0x1C and 0x20 | drive fields |
| 0x24 to 0x30 | trigger codes |
| 0x34 | interrupt enables |
| 0x38 | pending bits |
| 0x3C | sample-clock control |

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every function and trigger slot reads 7 and no pin is driven. Pull, drive, data, enable, pending and sample-clock control all read 0, and `irq` is low.
- R2: Pin p's function code is a 3-bit field in function word p/8 at bit (p%8)*4. Bit 3 of each 4-bit slot reads back 0. Trigger words use the same layout at their own offsets.
- R3: Function code 1 turns on the pin's driver (`pin_oe` high). Codes 0, 2 to 6 and 7 leave it off.
- R4: Writing the data register drives `pin_out` bit p from write bit p. Reading the data register returns `pin_in` as it stood two clock edges earlier.
- R5: Pull and drive settings are 2 bits per pin. Pins 0 to 15 are in the first word and pins 16 to 31 in the word 4 bytes above, at bit (p&15)*2. The settings appear on `pin_pull` and `pin_drive` at bit 2p.
- R6: At a sample event, trigger code 0 sets pending on a 0-to-1 change since the previous sample event, and code 1 on a 1-to-0 change. Code 2 sets pending on a high level, code 3 on a low level, and code 4 on any change. Codes 5 to 7 never set pending, and nothing sets pending between sample events.
- R7: A level-triggered pending bit that software clears sets again at the next sample event if the level is still present.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A sample match in the same cycle as the clear wins.
- R9: `irq` is high exactly when some pin has both its pending bit and its enable bit set. Enables never change the pending bits.
- R10: In the sample-clock control register, bit 0 selects the tick source (0 = `tick_slow`, 1 = `tick_fast`) and bits [6:4] hold prescaler n. A sample event occurs on every 2^n-th pulse of the selected source. The other source is ignored, and the unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_slow | input | 1 | Slow sample-source enable pulse |
| tick_fast | input | 1 | Fast sample-source enable pulse |
| pin_in | input | NPIN | Pad input levels (asynchronous) |
| pin_out | output | NPIN | Output data to the pads |
| pin_oe | output | NPIN | Pad driver enables |
| pin_pull | output | 2*NPIN | Pull setting, 2 bits per pin |
| pin_drive | output | 2*NPIN | Drive strength, 2 bits per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest conditions to reach from the ports are the ones that depend on when sample events happen. Edge triggers compare against the previous sample event, not the previous clock. The prescaler only fires on the 2^n-th selected pulse, and a level trigger must set again after a clear. The bench never runs the tick sources freely. It raises each tick pulse itself, after giving the synchroniser two edges. This lets it track the last sampled level for all pins and predict every pending bit. Random trigger codes and pin levels cover the codes in mixed combinations, and directed sequences count prescaled pulses one by one.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_FUNC  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_PULL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DRIVE = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_IPEND = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_DEB   = 8'h3C;

  localparam int SLOT_W         = 4;
  localparam int CODE_W         = 3;
  localparam int SLOTS_PER_WORD = REG_W / SLOT_W;
  localparam int FIELD_W        = 2;
  localparam int FIELDS_PER_WRD = REG_W / FIELD_W;
  localparam int DEB_PRE_LSB    = 4;

  localparam logic [CODE_W-1:0] FN_OUT = 3'd1;
  localparam logic [CODE_W-1:0] FN_OFF = 3'd7;

  typedef enum logic [CODE_W-1:0] {
    TRIG_RISE = 3'd0,
    TRIG_FALL = 3'd1,
    TRIG_HIGH = 3'd2,
    TRIG_LOW  = 3'd3,
    TRIG_ANY  = 3'd4
  } trig_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_deb_tick.sv
module gpio_deb_tick #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             src_fast,
  input  logic [PRE_W-1:0] pre,
  output logic             smp_en
);
  localparam int CNT_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             tick;

  assign tick   = src_fast ? tick_fast : tick_slow;
  // 2^pre - 1; wraps correctly at the widest prescale
  assign limit  = (CNT_W'(1) << pre) - CNT_W'(1);
  assign smp_en = tick && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= smp_en ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_en,
  input  logic [NPIN-1:0]              lvl,
  input  logic [NPIN-1:0][CODE_W-1:0]  trig,
  input  logic [NPIN-1:0]              clr,
  output logic [NPIN-1:0]              pend
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic prev_q;
    logic match;

    always_comb begin
      match = 1'b0;
      case (trig_e'(trig[i]))
        TRIG_RISE: match =  lvl[i] & ~prev_q;
        TRIG_FALL: match = ~lvl[i] &  prev_q;
        TRIG_HIGH: match =  lvl[i];
        TRIG_LOW:  match = ~lvl[i];
        TRIG_ANY:  match =  lvl[i] ^  prev_q;
        default:   match = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        if (smp_en) prev_q <= lvl[i];
        // a new match in the clearing cycle is kept
        pend[i] <= (smp_en & match) | (pend[i] & ~clr[i]);
      end
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPIN  = 32,
  parameter int PRE_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic                tick_slow,
  input  logic                tick_fast,
  input  logic [NPIN-1:0]     pin_in,
  output logic [NPIN-1:0]     pin_out,
  output logic [NPIN-1:0]     pin_oe,
  output logic [2*NPIN-1:0]   pin_pull,
  output logic [2*NPIN-1:0]   pin_drive,
  output logic                irq
);
  logic [CODE_W-1:0]             fn_q [NPIN];
  logic [NPIN-1:0][CODE_W-1:0]   trig_q;
  logic [FIELD_W-1:0]            pull_q [NPIN];
  logic [FIELD_W-1:0]            drv_q  [NPIN];
  logic [NPIN-1:0]               dout_q;
  logic [NPIN-1:0]               ien_q;
  logic                          deb_src_q;
  logic [PRE_W-1:0]              deb_pre_q;

  logic [NPIN-1:0] lvl_sync;
  logic [NPIN-1:0] pend_vec;
  logic [NPIN-1:0] pend_clr;
  logic            smp_en;
  logic            wr_en;
  logic            unused_wbits;

  assign wr_en        = bus_sel & bus_wr;
  assign unused_wbits = ^bus_wdata;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base, input int p);
    return base + ADDR_W'(4 * (p / SLOTS_PER_WORD));
  endfunction

  function automatic logic [ADDR_W-1:0] field_addr(input logic [ADDR_W-1:0] base, input int p);
    return base + ADDR_W'(4 * (p / FIELDS_PER_WRD));
  endfunction

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIN; p++) begin
        fn_q[p]   <= FN_OFF;
        trig_q[p] <= 3'd7;
        pull_q[p] <= '0;
        drv_q[p]  <= '0;
      end
      dout_q    <= '0;
      ien_q     <= '0;
      deb_src_q <= 1'b0;
      deb_pre_q <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NPIN; p++) begin
        if (bus_addr == slot_addr(OFS_FUNC, p))
          fn_q[p] <= bus_wdata[(p % SLOTS_PER_WORD) * SLOT_W +: CODE_W];
        if (bus_addr == slot_addr(OFS_TRIG, p))
          trig_q[p] <= bus_wdata[(p % SLOTS_PER_WORD) * SLOT_W +: CODE_W];
        if (bus_addr == field_addr(OFS_PULL, p))
          pull_q[p] <= bus_wdata[(p % FIELDS_PER_WRD) * FIELD_W +: FIELD_W];
        if (bus_addr == field_addr(OFS_DRIVE, p))
          drv_q[p] <= bus_wdata[(p % FIELDS_PER_WRD) * FIELD_W +: FIELD_W];
      end
      if (bus_addr == OFS_LEVEL) dout_q <= bus_wdata[NPIN-1:0];
      if (bus_addr == OFS_IEN)   ien_q  <= bus_wdata[NPIN-1:0];
      if (bus_addr == OFS_DEB) begin
        deb_src_q <= bus_wdata[0];
        deb_pre_q <= bus_wdata[DEB_PRE_LSB +: PRE_W];
      end
    end
  end

  assign pend_clr = (wr_en && bus_addr == OFS_IPEND) ? bus_wdata[NPIN-1:0] : '0;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      for (int p = 0; p < NPIN; p++) begin
        if (bus_addr == slot_addr(OFS_FUNC, p))
          bus_rdata[(p % SLOTS_PER_WORD) * SLOT_W +: CODE_W] = fn_q[p];
        if (bus_addr == slot_addr(OFS_TRIG, p))
          bus_rdata[(p % SLOTS_PER_WORD) * SLOT_W +: CODE_W] = trig_q[p];
        if (bus_addr == field_addr(OFS_PULL, p))
          bus_rdata[(p % FIELDS_PER_WRD) * FIELD_W +: FIELD_W] = pull_q[p];
        if (bus_addr == field_addr(OFS_DRIVE, p))
          bus_rdata[(p % FIELDS_PER_WRD) * FIELD_W +: FIELD_W] = drv_q[p];
      end
      if (bus_addr == OFS_LEVEL) bus_rdata[NPIN-1:0] = lvl_sync;
      if (bus_addr == OFS_IEN)   bus_rdata[NPIN-1:0] = ien_q;
      if (bus_addr == OFS_IPEND) bus_rdata[NPIN-1:0] = pend_vec;
      if (bus_addr == OFS_DEB) begin
        bus_rdata[0]                     = deb_src_q;
        bus_rdata[DEB_PRE_LSB +: PRE_W]  = deb_pre_q;
      end
    end
  end

  // pad-facing outputs
  for (genvar p = 0; p < NPIN; p++) begin : g_pad
    assign pin_oe[p]                     = (fn_q[p] == FN_OUT);
    assign pin_pull[p*FIELD_W +: FIELD_W]  = pull_q[p];
    assign pin_drive[p*FIELD_W +: FIELD_W] = drv_q[p];
  end
  assign pin_out = dout_q;

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (lvl_sync)
  );

  gpio_deb_tick #(.PRE_W(PRE_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .src_fast  (deb_src_q),
    .pre       (deb_pre_q),
    .smp_en    (smp_en)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (smp_en),
    .lvl    (lvl_sync),
    .trig   (trig_q),
    .clr    (pend_clr),
    .pend   (pend_vec)
  );

  assign irq = |(pend_vec & ien_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              tick_slow,
  input logic              tick_fast,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq,
  input logic              smp_en,
  input logic [NPIN-1:0]   pend
);
  a_r3_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pin_oe));

  a_r6_no_set_off_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ((pend & ~$past(pend)) == '0));

  a_r8_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_IPEND && !smp_en)
      |=> ((pend & $past(bus_wdata[NPIN-1:0])) == '0));

  a_r9_mask_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_IEN && bus_wdata[NPIN-1:0] == '0) |=> !irq);

  a_r10_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> (tick_slow || tick_fast));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tick_slow (tick_slow),
  .tick_fast (tick_fast),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .smp_en    (smp_en),
  .pend      (pend_vec)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          tick_slow = 1'b0;
  logic          tick_fast = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [2*NP-1:0] pin_pull, pin_drive;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [NP-1:0]       exp_pend = '0;
  logic [NP-1:0]       smp_prev = '0;
  logic [NP-1:0][2:0]  cur_ty;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull(pin_pull),
    .pin_drive(pin_drive), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [NP-1:0] hits(input logic [NP-1:0] cur, input logic [NP-1:0] prv,
                                          input logic [NP-1:0][2:0] ty);
    logic [NP-1:0] h = '0;
    for (int i = 0; i < NP; i++) begin
      case (ty[i])
        3'd0: h[i] =  cur[i] & ~prv[i];
        3'd1: h[i] = ~cur[i] &  prv[i];
        3'd2: h[i] =  cur[i];
        3'd3: h[i] = ~cur[i];
        3'd4: h[i] =  cur[i] ^  prv[i];
        default: h[i] = 1'b0;
      endcase
    end
    return h;
  endfunction

  task automatic set_types(input logic [NP-1:0][2:0] ty);
    for (int w = 0; w < 4; w++) begin
      logic [31:0] word = '0;
      for (int i = 0; i < 8; i++) word[i*4 +: 3] = ty[w*8+i];
      bus_write(8'h24 + 8'(4*w), word);
    end
    cur_ty = ty;
  endtask

  // drive levels, let the synchroniser settle, fire one slow tick (prescale 0)
  task automatic sample_levels(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
    @(negedge clk);
    tick_slow = 1'b1;
    @(negedge clk);
    tick_slow = 1'b0;
    exp_pend = exp_pend | hits(v, smp_prev, cur_ty);
    smp_prev = v;
  endtask

  task automatic clear_pend(input logic [NP-1:0] m);
    bus_write(8'h38, m);
    exp_pend = exp_pend & ~m;
  endtask

  task automatic pulse_fast(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_fast = 1'b1;
      @(negedge clk); tick_fast = 1'b0;
    end
  endtask

  task automatic pulse_slow(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_slow = 1'b1;
      @(negedge clk); tick_slow = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] w0, w1;
    logic [NP-1:0] v, m;
    logic [NP-1:0][2:0] ty;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 oe", 64'(pin_oe), 64'h0);
    check("R1 pull", pin_pull, 64'h0);
    check("R1 drive", pin_drive, 64'h0);
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 out", 64'(pin_out), 64'h0);
    bus_read(8'h00, rd); check("R1 func word0", 64'(rd), 64'h77777777);
    bus_read(8'h30, rd); check("R1 trig word3", 64'(rd), 64'h77777777);
    bus_read(8'h34, rd); check("R1 enables", 64'(rd), 64'h0);
    bus_read(8'h38, rd); check("R1 pending", 64'(rd), 64'h0);
    bus_read(8'h3C, rd); check("R1 sample ctl", 64'(rd), 64'h0);

    // R2/R3 function slots and driver enables
    for (int r = 0; r < 3; r++) begin
      logic [NP-1:0] exp_oe = '0;
      for (int w = 0; w < 4; w++) begin
        logic [31:0] word = $urandom;
        if (r == 0) word = 32'hF1E1_9810; // directed: codes 0,1,7 and bit 3 set
        bus_write(8'(4*w), word);
        bus_read(8'(4*w), rd);
        check("R2 func readback", 64'(rd), 64'(word & 32'h77777777));
        for (int i = 0; i < 8; i++) exp_oe[w*8+i] = (word[i*4 +: 3] == 3'd1);
      end
      check("R3 pin_oe", 64'(pin_oe), 64'(exp_oe));
    end

    // R4 data out and level read-back
    for (int r = 0; r < 3; r++) begin
      v = $urandom;
      bus_write(8'h10, v);
      check("R4 pin_out", 64'(pin_out), 64'(v));
      m = $urandom;
      @(negedge clk); pin_in = m;
      @(negedge clk);
      bus_read(8'h10, rd);
      check("R4 level read", 64'(rd), 64'(m));
    end
    pin_in = '0;
    repeat (3) @(negedge clk);

    // R5 pull and drive fields
    w0 = $urandom; w1 = $urandom;
    bus_write(8'h14, w0); bus_write(8'h18, w1);
    check("R5 pin_pull", pin_pull, {w1, w0});
    bus_read(8'h18, rd); check("R5 pull word1", 64'(rd), 64'(w1));
    w0 = $urandom; w1 = $urandom;
    bus_write(8'h1C, w0); bus_write(8'h20, w1);
    check("R5 pin_drive", pin_drive, {w1, w0});

    // R6/R8/R9 random trigger codes and levels
    cur_ty = '1;
    for (int r = 0; r < 24; r++) begin
      for (int i = 0; i < NP; i++) ty[i] = 3'($urandom % 8);
      set_types(ty);
      bus_read(8'h28, rd);
      check("R2 trig word1", 64'(rd[2:0]), 64'(ty[8]));
      v = $urandom;
      sample_levels(v);
      bus_read(8'h38, rd);
      check("R6 pending after sample", 64'(rd), 64'(exp_pend));
      m = $urandom;
      bus_write(8'h34, m);
      check("R9 irq", 64'(irq), 64'(|(exp_pend & m)));
      m = $urandom;
      clear_pend(m);
      bus_read(8'h38, rd);
      check("R8 pending after clear", 64'(rd), 64'(exp_pend));
    end
    bus_write(8'h34, 32'h0);
    clear_pend('1);

    // R7 level re-assert, codes 5..7 inert, write-zero no effect
    ty = '1; ty[5] = 3'd2;
    set_types(ty);
    v = smp_prev; v[5] = 1'b1;
    sample_levels(v);
    bus_read(8'h38, rd); check("R6 high level sets", 64'(rd[5]), 64'h1);
    clear_pend(32'h20);
    bus_read(8'h38, rd); check("R8 cleared", 64'(rd[5]), 64'h0);
    sample_levels(v);
    bus_read(8'h38, rd); check("R7 level sets again", 64'(rd[5]), 64'h1);
    bus_write(8'h38, 32'h0);
    bus_read(8'h38, rd); check("R8 write zero keeps", 64'(rd), 64'(exp_pend));
    bus_write(8'h34, 32'h20);
    check("R9 irq enabled", 64'(irq), 64'h1);
    bus_write(8'h34, 32'h0);
    check("R9 irq masked", 64'(irq), 64'h0);
    bus_read(8'h38, rd); check("R9 mask keeps pending", 64'(rd[5]), 64'h1);
    clear_pend('1);
    ty[5] = 3'd6;
    set_types(ty);
    v[5] = 1'b0; sample_levels(v);
    v[5] = 1'b1; sample_levels(v);
    bus_read(8'h38, rd); check("R6 code 6 inert", 64'(rd), 64'h0);

    // R10 sample-clock source and prescaler
    bus_write(8'h3C, 32'hFFFF_FFFF);
    bus_read(8'h3C, rd); check("R10 ctl readback", 64'(rd), 64'h71);
    bus_write(8'h3C, 32'h0000_0000);
    pulse_slow(1); // prescale 0: counter back at zero
    ty[5] = 3'd2;
    set_types(ty);
    bus_write(8'h3C, 32'h0000_0021); // fast source, divide by 4
    bus_write(8'h38, '1);
    bus_read(8'h38, rd); check("R10 start clear", 64'(rd), 64'h0);
    pulse_slow(4);
    bus_read(8'h38, rd); check("R10 slow source ignored", 64'(rd), 64'h0);
    pulse_fast(3);
    bus_read(8'h38, rd); check("R10 before 4th pulse", 64'(rd), 64'h0);
    pulse_fast(1);
    bus_read(8'h38, rd); check("R10 on 4th pulse", 64'(rd[5]), 64'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule